// File: doc/BRIEF.md
# Four-Channel Triggered DMA Controller

This block moves data between memory locations on behalf of a processor, using four independent channels. Software programs each channel with a source address, a destination address, a unit count and a 16-bit control word. Setting the enable bit arms the channel. Depending on its start-timing field, the channel then begins at once or waits for one of three triggers: a horizontal-blank pulse, a vertical-blank pulse, or a sound-FIFO refill request.

A running channel performs one unit copy per step on a single shared memory port. The port has a request/acknowledge handshake and presents the source address, the destination address and the unit size (16 or 32 bits). When several channels are busy at once, a fixed-priority selector hands the port to the lowest-numbered one. Each step therefore advances exactly one channel.

Each channel has its own address widths and counter width. It supports increment, decrement, fixed and increment-with-reload address stepping, repeat blocks re-armed by the next trigger, and an optional end-of-block interrupt pulse.

Top module: `dma_quad`

## Requirements
- R1: Source addresses are masked on write and after every step: to 27 bits on channel 0 and to 28 bits on channels 1 to 3.
- R2: Destination addresses are masked to 27 bits on channels 0 to 2 and to 28 bits on channel 3.
- R3: Control word layout: bits [1:0] destination adjust, [3:2] source adjust, [4] repeat, [5] 32-bit units, [7:6] start timing, [8] interrupt enable, [15] enable. A 0-to-1 change of enable loads the working source, destination and count from the programmed values. The channel starts at once only when start timing is 00.
- R4: A programmed count of 0 means 2^W units, where W is the counter width: 14 bits on channels 0 to 2 and 16 bits on channel 3.
- R5: An idle, enabled channel starts on an hblank pulse when its start timing is 10, and on a vblank pulse when it is 01. A pulse of the other kind is ignored.
- R6: When a blanking trigger starts a repeating channel, the count reloads from the programmed value. The working destination reloads only when destination adjust is 11; otherwise it continues from where the last block stopped.
- R7: Channels 1 and 2 with start timing 11 are in FIFO mode. A fifo_req pulse starts such a channel only if it is enabled and repeating. It then runs exactly 4 units of 32 bits with a fixed destination. fifo_req has no effect on channels 0 and 3.
- R8: After the last unit of a block the channel stops being busy, whether or not repeat is set. A non-repeating channel also clears its enable bit, so later triggers do not restart it.
- R9: At most one channel is granted per cycle, and always the lowest-numbered busy one. mem_req is high exactly when some channel is busy.
- R10: Adjust encoding: 00 increments, 01 decrements, 10 holds fixed, 11 increments (and reloads the destination on repeat). The step is 2 bytes for 16-bit units and 4 bytes for 32-bit units.
- R11: At block end, if interrupt enable is set, the channel's irq output pulses high for exactly one cycle. If it is clear, irq stays low.
- R12: A step completes only in a cycle where mem_ack is high. Without it, the presented addresses and the remaining count hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_ch | input | 2 | Channel selected for the write |
| reg_sel | input | 2 | Register: 0 source, 1 destination, 2 count, 3 control |
| reg_wdata | input | 32 | Write data (control uses bits [15:0]) |
| hblank | input | 1 | Horizontal-blank trigger pulse |
| vblank | input | 1 | Vertical-blank trigger pulse |
| fifo_req | input | 4 | Per-channel sound FIFO refill request |
| mem_req | output | 1 | A unit copy is requested |
| mem_src | output | 32 | Source address of the granted channel |
| mem_dst | output | 32 | Destination address of the granted channel |
| mem_wide | output | 1 | 1 for a 32-bit unit, 0 for 16-bit |
| mem_ack | input | 1 | Memory completes the requested copy this cycle |
| busy | output | 4 | Per-channel in-progress flags |
| irq | output | 4 | Per-channel end-of-block interrupt pulses |

## Verification
The bench uses the default parameters: four channels, 27- and 28-bit address masks, 14- and 16-bit counters, and FIFO capability on channels 1 and 2. With these sizes a zero count expands to 16384 units on channel 0 and 65536 units on channel 3, and the bench runs both in full, so the wrap of the counter is observed directly rather than inferred. The default mask widths also make it possible to write all-ones addresses and see the exact 27/28-bit cut on every channel. The priority test holds mem_ack low while two channels become busy, so the arbitration order can be seen at the port.

// File: rtl/dma_pkg.sv
package dma_pkg;

    localparam int ADDR_W = 32;

    typedef enum logic [1:0] {
        ADJ_INC = 2'b00,
        ADJ_DEC = 2'b01,
        ADJ_FIX = 2'b10,
        ADJ_RLD = 2'b11
    } adj_e;

    typedef enum logic [1:0] {
        START_NOW = 2'b00,
        START_VBL = 2'b01,
        START_HBL = 2'b10,
        START_SPC = 2'b11
    } start_e;

    typedef enum logic [1:0] {
        SEL_SRC = 2'b00,
        SEL_DST = 2'b01,
        SEL_CNT = 2'b10,
        SEL_CTL = 2'b11
    } sel_e;

    typedef struct packed {
        logic       enable;   // [15]
        logic [5:0] rsvd;     // [14:9]
        logic       irq_en;   // [8]
        start_e     start;    // [7:6]
        logic       wide;     // [5]
        logic       rpt;      // [4]
        adj_e       src_adj;  // [3:2]
        adj_e       dst_adj;  // [1:0]
    } ctl_t;

    function automatic logic [ADDR_W-1:0] adj_addr(
        input logic [ADDR_W-1:0] a,
        input adj_e              mode,
        input logic              wide
    );
        logic [ADDR_W-1:0] stp;
        stp = wide ? ADDR_W'(4) : ADDR_W'(2);
        case (mode)
            ADJ_DEC: adj_addr = a - stp;
            ADJ_FIX: adj_addr = a;
            default: adj_addr = a + stp;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] low_mask(input int bits);
        logic [ADDR_W-1:0] m;
        m = '0;
        for (int i = 0; i < ADDR_W; i++)
            if (i < bits) m[i] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/dma_prio.sv
module dma_prio #(
    parameter int N = 4
) (
    input  logic [N-1:0] busy,
    output logic [N-1:0] grant
);
    always_comb begin
        grant = '0;
        for (int i = N - 1; i >= 0; i--)
            if (busy[i]) grant = N'(1) << i;
    end
endmodule

// File: rtl/dma_chan.sv
module dma_chan
    import dma_pkg::*;
#(
    parameter int SRC_BITS = 28,
    parameter int DST_BITS = 27,
    parameter int CNT_W    = 14,
    parameter bit FIFO_OK  = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  sel_e              wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              hblank,
    input  logic              vblank,
    input  logic              fifo_req,
    input  logic              grant,
    input  logic              mem_ack,
    output logic              busy,
    output logic [ADDR_W-1:0] cur_src,
    output logic [ADDR_W-1:0] cur_dst,
    output logic              cur_wide,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] SRC_MASK = low_mask(SRC_BITS);
    localparam logic [ADDR_W-1:0] DST_MASK = low_mask(DST_BITS);

    logic [ADDR_W-1:0] sad, dad, w_src, w_dst;
    logic [CNT_W-1:0]  cnt_prog, w_cnt;
    ctl_t              ctl, new_ctl;
    logic              in_prog;
    logic              fifo_mode, step, last, blank_hit;
    adj_e              dst_mode;

    assign new_ctl   = ctl_t'(wr_data[15:0]);
    assign fifo_mode = FIFO_OK && (ctl.start == START_SPC);
    assign dst_mode  = fifo_mode ? ADJ_FIX : ctl.dst_adj;
    assign step      = in_prog && grant && mem_ack;
    assign last      = (w_cnt == CNT_W'(1));
    assign blank_hit = (hblank && ctl.start == START_HBL) ||
                       (vblank && ctl.start == START_VBL);

    always_ff @(posedge clk) begin
        if (rst) begin
            sad      <= '0;
            dad      <= '0;
            w_src    <= '0;
            w_dst    <= '0;
            cnt_prog <= '0;
            w_cnt    <= '0;
            ctl      <= '0;
            in_prog  <= 1'b0;
            irq      <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (step) begin
                w_src <= adj_addr(w_src, ctl.src_adj, ctl.wide) & SRC_MASK;
                w_dst <= adj_addr(w_dst, dst_mode, ctl.wide) & DST_MASK;
                w_cnt <= w_cnt - CNT_W'(1);
                if (last) begin
                    in_prog <= 1'b0;
                    irq     <= ctl.irq_en;
                    if (!ctl.rpt) ctl.enable <= 1'b0;
                end
            end
            if (!in_prog && ctl.enable && blank_hit) begin
                in_prog <= 1'b1;
                if (ctl.rpt) begin
                    w_cnt <= cnt_prog;
                    if (ctl.dst_adj == ADJ_RLD) w_dst <= dad;
                end
            end
            if (fifo_req && fifo_mode && ctl.enable && ctl.rpt) begin
                w_cnt    <= CNT_W'(4);
                ctl.wide <= 1'b1;
                in_prog  <= 1'b1;
            end
            if (wr_en) begin
                case (wr_sel)
                    SEL_SRC: sad      <= wr_data & SRC_MASK;
                    SEL_DST: dad      <= wr_data & DST_MASK;
                    SEL_CNT: cnt_prog <= wr_data[CNT_W-1:0];
                    default: begin
                        ctl <= new_ctl;
                        if (new_ctl.enable && !ctl.enable) begin
                            w_src   <= sad;
                            w_dst   <= dad;
                            w_cnt   <= cnt_prog;
                            in_prog <= (new_ctl.start == START_NOW);
                        end
                    end
                endcase
            end
        end
    end

    assign busy     = in_prog;
    assign cur_src  = w_src;
    assign cur_dst  = w_dst;
    assign cur_wide = ctl.wide;

    AST_SRC_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (w_src & ~SRC_MASK) == '0);                                   // R1
    AST_DST_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (w_dst & ~DST_MASK) == '0);                                   // R2
    AST_HOLD_NO_ACK: assert property (@(posedge clk) disable iff (rst)
        (in_prog && !mem_ack && !wr_en) |=> ($stable(w_src) && $stable(w_cnt))); // R12
    AST_FIFO_DST_FIXED: assert property (@(posedge clk) disable iff (rst)
        (step && fifo_mode && !wr_en) |=> $stable(w_dst));            // R7
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);                                                // R11
endmodule

// File: rtl/dma_quad.sv
module dma_quad
    import dma_pkg::*;
#(
    parameter int                 NUM_CH    = 4,
    parameter int                 SHORT_AW  = 27,
    parameter int                 LONG_AW   = 28,
    parameter int                 SHORT_CW  = 14,
    parameter int                 LONG_CW   = 16,
    parameter logic [NUM_CH-1:0]  FIFO_MASK = 4'b0110,
    localparam int                CH_W      = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [CH_W-1:0]   reg_ch,
    input  logic [1:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    input  logic              hblank,
    input  logic              vblank,
    input  logic [NUM_CH-1:0] fifo_req,
    output logic              mem_req,
    output logic [31:0]       mem_src,
    output logic [31:0]       mem_dst,
    output logic              mem_wide,
    input  logic              mem_ack,
    output logic [NUM_CH-1:0] busy,
    output logic [NUM_CH-1:0] irq
);
    logic [NUM_CH-1:0] grant;
    logic [NUM_CH-1:0] ch_wide;
    logic [ADDR_W-1:0] ch_src [NUM_CH];
    logic [ADDR_W-1:0] ch_dst [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        dma_chan #(
            .SRC_BITS (g == 0          ? SHORT_AW : LONG_AW),
            .DST_BITS (g == NUM_CH - 1 ? LONG_AW  : SHORT_AW),
            .CNT_W    (g == NUM_CH - 1 ? LONG_CW  : SHORT_CW),
            .FIFO_OK  (FIFO_MASK[g])
        ) u_chan (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (reg_we && (reg_ch == CH_W'(g))),
            .wr_sel   (sel_e'(reg_sel)),
            .wr_data  (reg_wdata),
            .hblank   (hblank),
            .vblank   (vblank),
            .fifo_req (fifo_req[g]),
            .grant    (grant[g]),
            .mem_ack  (mem_ack),
            .busy     (busy[g]),
            .cur_src  (ch_src[g]),
            .cur_dst  (ch_dst[g]),
            .cur_wide (ch_wide[g]),
            .irq      (irq[g])
        );
    end

    dma_prio #(.N(NUM_CH)) u_prio (
        .busy  (busy),
        .grant (grant)
    );

    always_comb begin
        mem_src  = '0;
        mem_dst  = '0;
        mem_wide = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (grant[i]) begin
                mem_src  = mem_src | ch_src[i];
                mem_dst  = mem_dst | ch_dst[i];
                mem_wide = mem_wide | ch_wide[i];
            end
        end
    end

    assign mem_req = |grant;

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));                                             // R9
    AST_GRANT_IS_BUSY: assert property (@(posedge clk) disable iff (rst)
        (grant & ~busy) == '0);                                       // R9
    AST_REQ_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        mem_req == (busy != '0));                                     // R9
endmodule

// File: tb/dma_quad_bench.sv
module dma_quad_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_ch = '0;
    logic [1:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic        hblank = 1'b0;
    logic        vblank = 1'b0;
    logic [3:0]  fifo_req = '0;
    logic        mem_req, mem_wide, mem_ack;
    logic [31:0] mem_src, mem_dst;
    logic [3:0]  busy, irq;
    logic        ack_en = 1'b0;

    int tests = 0;
    int fails = 0;
    int n_log = 0;
    int irq_cnt [4];
    logic [31:0] log_src [256];
    logic [31:0] log_dst [256];
    logic        log_wide [256];

    always #4 clk = ~clk;

    assign mem_ack = mem_req & ack_en;

    dma_quad u_dma_quad (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_ch(reg_ch),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .hblank(hblank),
        .vblank(vblank), .fifo_req(fifo_req), .mem_req(mem_req),
        .mem_src(mem_src), .mem_dst(mem_dst), .mem_wide(mem_wide),
        .mem_ack(mem_ack), .busy(busy), .irq(irq)
    );

    initial for (int i = 0; i < 4; i++) irq_cnt[i] = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (mem_req && mem_ack) begin
                if (n_log < 256) begin
                    log_src[n_log]  = mem_src;
                    log_dst[n_log]  = mem_dst;
                    log_wide[n_log] = mem_wide;
                end
                n_log = n_log + 1;
            end
            for (int i = 0; i < 4; i++)
                if (irq[i]) irq_cnt[i] = irq_cnt[i] + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_ctl(input bit en, input bit ie, input logic [1:0] st,
                                           input bit wd, input bit rp,
                                           input logic [1:0] sa, input logic [1:0] da);
        return {16'h0, en, 6'b0, ie, st, wd, rp, sa, da};
    endfunction

    task automatic wr(input int ch, input int sel, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_ch = 2'(ch); reg_sel = 2'(sel); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic prog(input int ch, input logic [31:0] s, input logic [31:0] d,
                        input logic [31:0] c, input logic [31:0] ctl);
        wr(ch, 0, s); wr(ch, 1, d); wr(ch, 2, c); wr(ch, 3, ctl);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 70000; i++) begin
            if (busy == 4'b0) break;
            @(negedge clk);
        end
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic pulse(input int kind, input int ch);
        @(negedge clk);
        if (kind == 0) hblank = 1'b1;
        else if (kind == 1) vblank = 1'b1;
        else fifo_req[ch] = 1'b1;
        @(negedge clk);
        hblank = 1'b0; vblank = 1'b0; fifo_req = '0;
        wait_idle();
    endtask

    task automatic t_reset();
        chk("R9 reset busy", 32'(busy), 0);
        chk("R11 reset irq", 32'(irq), 0);
        chk("R9 reset mem_req", 32'(mem_req), 0);
    endtask

    task automatic t_immediate();
        int b = n_log;
        int ib = irq_cnt[0];
        ack_en = 1'b0;
        prog(0, 32'hFFFF_FF00, 32'h0300_0000, 3, mk_ctl(1, 1, 2'b00, 0, 0, 2'b00, 2'b01));
        chk("R3 immediate start busy", 32'(busy[0]), 1);
        chk("R1 ch0 source mask", mem_src, 32'h07FF_FF00);
        repeat (3) @(negedge clk);
        chk("R12 no step without ack", n_log - b, 0);
        chk("R12 address held", mem_src, 32'h07FF_FF00);
        ack_en = 1'b1;
        wait_idle();
        chk("R10 three units", n_log - b, 3);
        chk("R10 src inc 16-bit", log_src[b+2], 32'h07FF_FF04);
        chk("R10 dst dec 16-bit", log_dst[b+1], 32'h02FF_FFFE);
        chk("R10 dst dec 16-bit", log_dst[b+2], 32'h02FF_FFFC);
        chk("R11 one irq pulse", irq_cnt[0] - ib, 1);
        chk("R8 idle after block", 32'(busy[0]), 0);
    endtask

    task automatic t_ch3_masks();
        int b = n_log;
        int ib = irq_cnt[3];
        prog(3, 32'hFFFF_FFF0, 32'hFFFF_FFF0, 2, mk_ctl(1, 0, 2'b00, 1, 0, 2'b10, 2'b00));
        wait_idle();
        chk("R1 ch3 source mask", log_src[b], 32'h0FFF_FFF0);
        chk("R10 src fixed", log_src[b+1], 32'h0FFF_FFF0);
        chk("R2 ch3 dest mask", log_dst[b], 32'h0FFF_FFF0);
        chk("R10 dst inc 32-bit", log_dst[b+1], 32'h0FFF_FFF4);
        chk("R10 wide unit", 32'(log_wide[b]), 1);
        chk("R11 no irq when disabled", irq_cnt[3] - ib, 0);
    endtask

    task automatic t_hblank();
        int b = n_log;
        ack_en = 1'b1;
        prog(2, 32'h1FFF_FFF0, 32'hFFFF_FFFC, 1, mk_ctl(1, 0, 2'b10, 1, 0, 2'b00, 2'b00));
        repeat (3) @(negedge clk);
        chk("R3 timed channel waits", 32'(busy[2]), 0);
        pulse(1, 0);
        chk("R5 vblank ignored by hblank channel", n_log - b, 0);
        pulse(0, 0);
        chk("R5 hblank starts channel", n_log - b, 1);
        chk("R1 ch2 source mask", log_src[b], 32'h0FFF_FFF0);
        chk("R2 ch2 dest mask", log_dst[b], 32'h07FF_FFFC);
        pulse(0, 0);
        chk("R8 non-repeat not restarted", n_log - b, 1);
    endtask

    task automatic t_vblank_repeat();
        int b = n_log;
        prog(1, 32'h100, 32'h200, 2, mk_ctl(1, 0, 2'b01, 0, 1, 2'b00, 2'b11));
        pulse(1, 0);
        chk("R5 vblank first block", n_log - b, 2);
        chk("R8 repeat idle between triggers", 32'(busy[1]), 0);
        pulse(1, 0);
        chk("R6 count reloaded", n_log - b, 4);
        chk("R6 src continues", log_src[b+2], 32'h104);
        chk("R6 dst reloaded", log_dst[b+2], 32'h200);
        wr(1, 3, 0);
        b = n_log;
        prog(1, 32'h300, 32'h400, 1, mk_ctl(1, 0, 2'b01, 0, 1, 2'b00, 2'b00));
        pulse(1, 0);
        pulse(1, 0);
        chk("R6 count reloaded plain", n_log - b, 2);
        chk("R6 dst not reloaded", log_dst[b+1], 32'h402);
    endtask

    task automatic t_fifo();
        int b;
        wr(1, 3, 0);
        b = n_log;
        prog(1, 32'h1000, 32'h40, 7, mk_ctl(1, 0, 2'b11, 0, 1, 2'b00, 2'b00));
        repeat (2) @(negedge clk);
        chk("R7 special timing waits", 32'(busy[1]), 0);
        pulse(2, 1);
        chk("R7 four units", n_log - b, 4);
        chk("R7 forced wide", 32'(log_wide[b+3]), 1);
        chk("R7 src steps by 4", log_src[b+3], 32'h100C);
        chk("R7 dst fixed", log_dst[b+3], 32'h40);
        wr(3, 3, 0);
        b = n_log;
        prog(3, 32'h10, 32'h20, 1, mk_ctl(1, 0, 2'b11, 0, 1, 2'b00, 2'b00));
        pulse(2, 3);
        chk("R7 ch3 ignores fifo_req", n_log - b, 0);
    endtask

    task automatic t_priority();
        int b = n_log;
        ack_en = 1'b0;
        prog(2, 32'h2000, 32'h2100, 1, mk_ctl(1, 0, 2'b00, 0, 0, 2'b00, 2'b00));
        prog(0, 32'h5000, 32'h5100, 2, mk_ctl(1, 0, 2'b00, 0, 0, 2'b01, 2'b00));
        chk("R9 both busy", 32'(busy), 32'h5);
        chk("R9 lowest index granted", mem_src, 32'h5000);
        ack_en = 1'b1;
        wait_idle();
        chk("R10 src dec", log_src[b+1], 32'h4FFE);
        chk("R9 lower channel finishes first", log_src[b+2], 32'h2000);
    endtask

    task automatic t_zero_count();
        int b = n_log;
        prog(0, 32'h0, 32'h0, 0, mk_ctl(1, 0, 2'b00, 0, 0, 2'b10, 2'b10));
        wait_idle();
        chk("R4 ch0 zero count 16384", n_log - b, 16384);
        wr(3, 3, 0);
        b = n_log;
        prog(3, 32'h0, 32'h0, 0, mk_ctl(1, 0, 2'b00, 0, 0, 2'b10, 2'b10));
        wait_idle();
        chk("R4 ch3 zero count 65536", n_log - b, 65536);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_immediate();
        t_ch3_masks();
        t_hblank();
        t_vblank_repeat();
        t_fifo();
        t_priority();
        t_zero_count();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule